// File: doc/BRIEF.md
# Two-Line DMA Completion Interrupt Encoder

This block gathers completion events from 16 DMA channels into one sticky interrupt flag per channel. Each channel has a line-select bit that assigns its flag to one of two interrupt lines. For each line, the block continuously drives an 8-bit offset that identifies the highest-priority channel with a pending flag on that line.

Software services a line by reading its offset. The read strobe clears the flag that the offset names, and the offset then moves to the next pending channel on that line. Flags can also be cleared by a masked write. The block also provides a summary bit that is high whenever any flag is set. A separate completion indicator stays set until software clears it.

The block is used between the DMA transfer engine, which pulses a channel's completion input, and the interrupt controller, which watches the two line outputs.

Top module: `dma_irq_offset_enc`

## Requirements
- R1: When `done_evt[i]` and `done_ien[i]` are both high at a clock edge, flag i is set after that edge. A completion with `done_ien[i]` low leaves flag i unchanged. A flag never becomes set without such an event.
- R2: Flag i belongs to line 1 when `lvl_sel[i]` is 1 and to line 0 when it is 0. A flag affects only the offset and interrupt output of its own line.
- R3: Each line offset equals the pending channel's number plus one, so channel 0 gives 1 and channel 15 gives 16. The offset is 0 when no flag on that line is set.
- R4: Priority among channels is fixed, with the lowest channel number highest.
- R5: A one-cycle `ofs_rd[l]` pulse clears the flag named by line l's offset at that edge. After that edge the offset shows the next pending channel on the line.
- R6: With `flag_wr_en` high, every bit of `flag_wr_data` that is 0 clears the matching flag. A bit that is 1 leaves its flag as it was.
- R7: `pend` equals the OR of all 16 flags.
- R8: `tc_flag` sets on any `done_evt` bit, whatever the enables are. It holds until a write with `tc_wr_en` high and `tc_wr_data` 0. Writing 1 has no effect.
- R9: `irq_line[l]` is high exactly while some flag routed to line l is set.
- R10: A flag, or `tc_flag`, that is set and cleared at the same edge ends up set.
- R11: After reset, all flags, `tc_flag`, both offsets and both lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_evt | input | 16 | Per-channel block-completion pulse |
| done_ien | input | 16 | Interrupt enable of the completing packet, per channel |
| lvl_sel | input | 16 | Per-channel line select (0: line 0, 1: line 1) |
| ofs_rd | input | 2 | Offset read strobe per line |
| flag_wr_en | input | 1 | Flag write strobe |
| flag_wr_data | input | 16 | Flag write data (0 clears, 1 keeps) |
| tc_wr_en | input | 1 | Completion-indicator write strobe |
| tc_wr_data | input | 1 | Completion-indicator write value (0 clears) |
| line0_ofs | output | 8 | Offset of the highest-priority pending channel on line 0 |
| line1_ofs | output | 8 | Offset of the highest-priority pending channel on line 1 |
| irq_line | output | 2 | Interrupt request per line |
| irq_flags | output | 16 | Per-channel interrupt flags |
| pend | output | 1 | OR of all flags |
| tc_flag | output | 1 | Sticky completion indicator |

## Verification
The embedded properties check the following on every cycle:
- Each nonzero offset points at a set flag on its own line, and no higher-priority flag on that line is set.
- Each line output agrees with its offset being nonzero.
- A cleared flag stays cleared unless it is set again in the same cycle, and a flag never appears without an enabled completion.
- A simultaneous set and clear leaves the flag set.

Some behaviour shows only in the bench scenarios:
- The exact offset values for the extreme channels.
- Draining a line through successive reads.
- Re-routing a pending channel by changing its line bit.
- The write-1-has-no-effect cases.

A behavioural reference model compared on every clock covers mixed random traffic.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    // Number of interrupt lines the channels are split across.
    localparam int unsigned LINES = 2;

    // Line identity as selected by a channel's level bit.
    typedef enum logic {
        LINE_LO = 1'b0,
        LINE_HI = 1'b1
    } line_e;

endpackage

// File: rtl/dmairq_prienc.sv
// Fixed-priority encoder: lowest index wins, output is index plus one,
// zero when the request vector is empty. Also returns the one-hot grant.
module dmairq_prienc #(
    parameter int unsigned N     = 16,
    parameter int unsigned OFS_W = 8
) (
    input  logic [N-1:0]     req,
    output logic [OFS_W-1:0] ofs,
    output logic [N-1:0]     gnt
);

    always_comb begin
        ofs = '0;
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                ofs = OFS_W'(i + 1);
                gnt = N'(1) << i;
            end
        end
    end

endmodule

// File: rtl/dmairq_flags.sv
// Flag bank and sticky completion indicator. Set has priority over clear.
module dmairq_flags #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic         tc_set,
    input  logic         tc_clr,
    output logic [N-1:0] flags_q,
    output logic         tc_q
);

    typedef struct packed {
        logic [N-1:0] flag;
        logic         tc;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = (st_q.flag & ~clr_vec) | set_vec;
        st_d.tc   = (st_q.tc & ~tc_clr) | tc_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flag;
    assign tc_q    = st_q.tc;

    // R1
    flag_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0));

    // R6
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0));

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & set_vec)) |=>
            ((flags_q & $past(clr_vec & set_vec)) == $past(clr_vec & set_vec)));

    // R8
    tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_q && !tc_clr) |=> tc_q);

    // R8
    tc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_set |=> tc_q);

endmodule

// File: rtl/dma_irq_offset_enc.sv
module dma_irq_offset_enc
    import dmairq_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done_evt,
    input  logic [NUM_CH-1:0] done_ien,
    input  logic [NUM_CH-1:0] lvl_sel,
    input  logic [LINES-1:0]  ofs_rd,
    input  logic              flag_wr_en,
    input  logic [NUM_CH-1:0] flag_wr_data,
    input  logic              tc_wr_en,
    input  logic              tc_wr_data,
    output logic [OFS_W-1:0]  line0_ofs,
    output logic [OFS_W-1:0]  line1_ofs,
    output logic [LINES-1:0]  irq_line,
    output logic [NUM_CH-1:0] irq_flags,
    output logic              pend,
    output logic              tc_flag
);

    logic [NUM_CH-1:0] flags_q;
    logic              tc_q;
    logic [NUM_CH-1:0] set_vec;
    logic [NUM_CH-1:0] rd_clr;
    logic [NUM_CH-1:0] wr_clr;
    logic [NUM_CH-1:0] clr_vec;
    logic              tc_set;
    logic              tc_clr;

    logic [NUM_CH-1:0] line_vec [LINES];
    logic [NUM_CH-1:0] gnt_arr  [LINES];
    logic [OFS_W-1:0]  ofs_arr  [LINES];
    logic [NUM_CH-1:0] above_mask [LINES];

    // Per-line request masking and priority encoding.
    for (genvar l = 0; l < LINES; l++) begin : g_line
        assign line_vec[l] = flags_q &
            ((line_e'(l) == LINE_HI) ? lvl_sel : ~lvl_sel);

        dmairq_prienc #(
            .N     (NUM_CH),
            .OFS_W (OFS_W)
        ) u_enc (
            .req (line_vec[l]),
            .ofs (ofs_arr[l]),
            .gnt (gnt_arr[l])
        );

        assign irq_line[l] = |line_vec[l];

        // Channels with a lower index than the reported one.
        assign above_mask[l] = (NUM_CH'(1) << (ofs_arr[l] - OFS_W'(1))) - NUM_CH'(1);

        // R3
        ofs_names_set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ofs_arr[l] != '0) |->
                (((line_vec[l] >> (ofs_arr[l] - OFS_W'(1))) & NUM_CH'(1)) != '0));

        // R4
        ofs_highest_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ofs_arr[l] != '0) |-> ((line_vec[l] & above_mask[l]) == '0));

        // R9
        line_matches_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_line[l] == (ofs_arr[l] != '0));

        // R5
        read_clears_named_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ofs_rd[l] && (ofs_arr[l] != '0) && ((gnt_arr[l] & set_vec) == '0)) |=>
                ((flags_q & $past(gnt_arr[l])) == '0));
    end

    // Clear sources: acknowledge by offset read, and masked write of zeros.
    always_comb begin
        rd_clr = '0;
        for (int l = 0; l < LINES; l++) begin
            if (ofs_rd[l]) begin
                rd_clr = rd_clr | gnt_arr[l];
            end
        end
    end

    assign wr_clr  = flag_wr_en ? ~flag_wr_data : '0;
    assign clr_vec = rd_clr | wr_clr;
    assign set_vec = done_evt & done_ien;
    assign tc_set  = |done_evt;
    assign tc_clr  = tc_wr_en & ~tc_wr_data;

    dmairq_flags #(
        .N (NUM_CH)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .tc_set  (tc_set),
        .tc_clr  (tc_clr),
        .flags_q (flags_q),
        .tc_q    (tc_q)
    );

    assign line0_ofs = ofs_arr[0];
    assign line1_ofs = ofs_arr[1];
    assign irq_flags = flags_q;
    assign pend      = |flags_q;
    assign tc_flag   = tc_q;

    // R2
    hi_flags_skip_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & ~lvl_sel) == '0) |-> !irq_line[0]);

    // R7
    pend_has_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> ((line0_ofs != '0) || (line1_ofs != '0)));

    // R7
    idle_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> (irq_line == '0));

endmodule

// File: tb/dma_irq_offset_enc_tb.sv
module dma_irq_offset_enc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] done_evt = '0;
    logic [15:0] done_ien = '0;
    logic [15:0] lvl_sel = '0;
    logic [1:0]  ofs_rd = '0;
    logic        flag_wr_en = 1'b0;
    logic [15:0] flag_wr_data = '0;
    logic        tc_wr_en = 1'b0;
    logic        tc_wr_data = 1'b0;
    logic [7:0]  line0_ofs, line1_ofs;
    logic [1:0]  irq_line;
    logic [15:0] irq_flags;
    logic        pend, tc_flag;

    int errors = 0;
    int checks = 0;
    bit done_f = 0;

    // Reference model state
    logic [15:0] m_flag = '0;
    logic        m_tc = 1'b0;

    always #10 clk = ~clk;

    dma_irq_offset_enc u_dut (
        .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .done_ien(done_ien),
        .lvl_sel(lvl_sel), .ofs_rd(ofs_rd), .flag_wr_en(flag_wr_en),
        .flag_wr_data(flag_wr_data), .tc_wr_en(tc_wr_en), .tc_wr_data(tc_wr_data),
        .line0_ofs(line0_ofs), .line1_ofs(line1_ofs), .irq_line(irq_line),
        .irq_flags(irq_flags), .pend(pend), .tc_flag(tc_flag)
    );

    function automatic int m_ofs(int line);
        for (int i = 0; i < 16; i++)
            if (m_flag[i] && (int'(lvl_sel[i]) == line)) return i + 1;
        return 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Model update at each edge, from inputs held stable since the last falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '0;
            m_tc   = 1'b0;
        end else begin
            logic [15:0] clr;
            int o;
            clr = '0;
            for (int l = 0; l < 2; l++) begin
                o = m_ofs(l);
                if (ofs_rd[l] && o != 0) clr[o-1] = 1'b1;
            end
            if (flag_wr_en) clr = clr | ~flag_wr_data;
            m_flag = (m_flag & ~clr) | (done_evt & done_ien);
            m_tc   = (m_tc && !(tc_wr_en && !tc_wr_data)) || (done_evt != 0);
        end
    end

    // Cycle-by-cycle comparison against the model.
    always begin
        @(posedge clk);
        #5;
        if (rst_n && !done_f) begin
            chk("R1", "flags", int'(irq_flags), int'(m_flag));
            chk("R3", "line0_ofs", int'(line0_ofs), m_ofs(0));
            chk("R3", "line1_ofs", int'(line1_ofs), m_ofs(1));
            chk("R7", "pend", int'(pend), int'(m_flag != 0));
            chk("R8", "tc_flag", int'(tc_flag), int'(m_tc));
            chk("R9", "irq_line0", int'(irq_line[0]), int'(m_ofs(0) != 0));
            chk("R9", "irq_line1", int'(irq_line[1]), int'(m_ofs(1) != 0));
        end
    end

    task automatic apply(input logic [15:0] evt, input logic [15:0] ien,
                         input logic [1:0] rd, input logic wen, input logic [15:0] wdat,
                         input logic twe, input logic tval);
        @(negedge clk);
        done_evt     = evt;
        done_ien     = ien;
        ofs_rd       = rd;
        flag_wr_en   = wen;
        flag_wr_data = wdat;
        tc_wr_en     = twe;
        tc_wr_data   = tval;
        @(posedge clk);
        #6;
        @(negedge clk);
        done_evt = '0; done_ien = '0; ofs_rd = '0;
        flag_wr_en = 1'b0; flag_wr_data = '0; tc_wr_en = 1'b0; tc_wr_data = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_f) begin
            done_f = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk("R11", "flags after reset", int'(irq_flags), 0);
        chk("R11", "tc after reset", int'(tc_flag), 0);
        chk("R11", "ofs0 after reset", int'(line0_ofs), 0);
        chk("R11", "ofs1 after reset", int'(line1_ofs), 0);
        chk("R11", "lines after reset", int'(irq_line), 0);

        lvl_sel = 16'hF0F0;
        // ch3 (line0) and ch7 (line1) enabled, ch5 completes without enable
        apply(16'h00A8, 16'h0088, 2'b00, 0, 0, 0, 0);
        chk("R1", "ien low leaves ch5 clear", int'(irq_flags), 16'h0088);
        chk("R3", "ch3 gives 4 on line0", int'(line0_ofs), 4);
        chk("R2", "ch7 routed to line1", int'(line1_ofs), 8);
        chk("R8", "tc set by completion", int'(tc_flag), 1);
        chk("R9", "both lines up", int'(irq_line), 3);

        apply(16'h0202, 16'h0202, 2'b00, 0, 0, 0, 0);
        chk("R4", "ch1 beats ch3/ch9", int'(line0_ofs), 2);

        apply(0, 0, 2'b01, 0, 0, 0, 0);
        chk("R5", "read moves to ch3", int'(line0_ofs), 4);
        apply(0, 0, 2'b01, 0, 0, 0, 0);
        chk("R5", "read moves to ch9", int'(line0_ofs), 10);
        chk("R5", "line1 untouched by line0 read", int'(line1_ofs), 8);

        apply(0, 0, 2'b00, 1, 16'hFDFF, 0, 0);
        chk("R6", "zero bit clears ch9, ones keep", int'(irq_flags), 16'h0080);
        chk("R3", "line0 empty gives 0", int'(line0_ofs), 0);
        chk("R9", "line0 low", int'(irq_line[0]), 0);

        apply(0, 0, 2'b00, 1, 16'hFFFF, 0, 0);
        chk("R6", "all-ones write no effect", int'(irq_flags), 16'h0080);

        apply(16'h0080, 16'h0080, 2'b10, 0, 0, 0, 0);
        chk("R10", "set beats read clear", int'(irq_flags), 16'h0080);
        apply(16'h0080, 16'h0080, 2'b00, 1, 16'h0000, 0, 0);
        chk("R10", "set beats write clear", int'(irq_flags), 16'h0080);

        apply(0, 0, 2'b00, 0, 0, 1, 1);
        chk("R8", "tc write 1 no effect", int'(tc_flag), 1);
        apply(0, 0, 2'b00, 0, 0, 1, 0);
        chk("R8", "tc write 0 clears", int'(tc_flag), 0);
        apply(16'h0001, 16'h0000, 2'b00, 0, 0, 1, 0);
        chk("R10", "tc set beats clear", int'(tc_flag), 1);

        apply(0, 0, 2'b00, 1, 16'h0000, 0, 0);
        chk("R6", "write zeros clears all", int'(irq_flags), 0);
        apply(16'h8001, 16'h8001, 2'b00, 0, 0, 0, 0);
        chk("R3", "ch0 gives 1", int'(line0_ofs), 1);
        chk("R3", "ch15 gives 16", int'(line1_ofs), 16);

        lvl_sel = 16'hF0F1;
        @(posedge clk);
        #6;
        chk("R2", "ch0 moved to line1", int'(line1_ofs), 1);
        chk("R2", "line0 empty after move", int'(line0_ofs), 0);

        apply(0, 0, 2'b10, 0, 0, 0, 0);
        chk("R5", "line1 next is ch15", int'(line1_ofs), 16);
        apply(0, 0, 2'b10, 0, 0, 0, 0);
        chk("R5", "line1 drained", int'(line1_ofs), 0);
        chk("R7", "pend low when empty", int'(pend), 0);

        apply(16'h0004, 16'h0004, 2'b00, 1, 16'h0000, 0, 0);
        chk("R10", "ch2 set beats write", int'(irq_flags), 16'h0004);
        chk("R7", "pend high", int'(pend), 1);

        // Mixed traffic, checked by the reference model every cycle.
        for (int n = 0; n < 400; n++) begin
            logic [15:0] e, ie, wd;
            logic [1:0] rd;
            e  = 16'($urandom) & 16'($urandom);
            ie = 16'($urandom);
            rd = 2'($urandom);
            wd = 16'($urandom) | 16'($urandom);
            if (n % 50 == 0) lvl_sel = 16'($urandom);
            apply(e, ie, rd, ($urandom % 4) == 0, wd, ($urandom % 8) == 0, 1'($urandom));
        end

        done_f = 1;
        summary();
        $finish;
    end

endmodule